// File: doc/BRIEF.md
# Filter Coefficient Store with Self-Loading Boot Reader

This block holds the coefficient memory of a multi-tap FIR datapath: 128 signed 16-bit words by default. The memory is filled in one of two ways. A host can write single coefficients through a valid/ready write port. Or the block fetches the whole set on its own from a byte-wide external EPROM, with no outside controller involved. A full fetch starts by itself when reset is released, and again each time the system raises a load request while the block is idle.

One EPROM can serve up to sixteen devices. Each device reads its own 256-byte region, chosen by a 4-bit device index. A coefficient is taken from two neighbouring bytes, low byte at the even offset first. The EPROM is modelled as a fixed access latency. The address is held for `RD_LAT` clocks and the data is captured at the end of that window. The filter datapath reads the memory through a plain port with a latency of one clock.

Back-pressure on the host port: a write is taken only on a clock edge where `host_valid` and `host_ready` are both high. `host_ready` is low for the whole of a download. A host that holds `host_valid` high waits until the download ends. A write offered and then withdrawn while `host_ready` is low has no effect.

Top module: `coef_store`

## Requirements
- R1: A download begins by itself when reset is released; `busy` is high during reset, and `done` rises exactly 256*RD_LAT clocks after the first rising edge with reset inactive.
- R2: During a download `ep_addr` is {dev_idx, byte offset}, which is dev_idx*256 plus the offset. The offset starts at 0 and climbs by one up to 255.
- R3: Coefficient i is stored as {byte at offset 2i+1, byte at offset 2i}: the low byte is read first.
- R4: Each EPROM address is held for RD_LAT clocks, and `ep_data` is captured on the RD_LAT-th rising edge after the address changed.
- R5: `busy` stays high from the start of a download until the edge that stores the last coefficient, and is low otherwise.
- R6: `done` is high for exactly one clock, starting at the edge that stores coefficient 127, and `busy` falls on that same edge.
- R7: A `load_req` sampled high while idle starts a full reload on that edge, so `done` follows 256*RD_LAT clocks later.
- R8: A `load_req` raised during a download has no effect: the download keeps its timing and `done` pulses once.
- R9: While idle, `host_ready` is high, and a write with `host_valid` high stores `host_data` at `host_addr`.
- R10: While `busy` is high, `host_ready` is low and a host write leaves the memory unchanged.
- R11: `rd_data` shows the coefficient at `rd_addr` one clock after `rd_addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_idx | input | 4 | Device index; selects the EPROM region |
| load_req | input | 1 | Request a full reload |
| busy | output | 1 | Download in progress |
| done | output | 1 | One-clock pulse when the download ends |
| ep_addr | output | 12 | EPROM byte address |
| ep_data | input | 8 | EPROM data byte |
| host_valid | input | 1 | Host write offered |
| host_ready | output | 1 | Host write can be accepted |
| host_addr | input | 7 | Host write coefficient index |
| host_data | input | 16 | Host write coefficient value |
| rd_addr | input | 7 | Datapath read index |
| rd_data | output | 16 | Datapath read value |

## Verification
The hardest case to reach is a download that is disturbed while it runs. This means a reload request and a host write arriving in the middle of the byte sequence, followed by a check that neither one shifted the timing or the stored data. The bench raises both partway through a download. It then counts edges to `done` and reads back every coefficient. Its EPROM model returns the inverted byte unless the address has been stable long enough, so a reader that captures data too early stores visibly wrong values.

// File: rtl/coef_store_pkg.sv
package coef_store_pkg;
  typedef enum logic {LD_IDLE, LD_RUN} ld_state_e;
endpackage

// File: rtl/coef_ram.sv
module coef_ram #(
  parameter int DEPTH = 128,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eprom_loader.sv
module eprom_loader
  import coef_store_pkg::*;
#(
  parameter int N_COEF  = 128,
  parameter int DEV_W   = 4,
  parameter int RD_LAT  = 3,
  localparam int BYTE_W = $clog2(N_COEF * 2),
  localparam int IDX_W  = $clog2(N_COEF),
  localparam int WAIT_W = $clog2(RD_LAT + 1),
  localparam int EA_W   = DEV_W + BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEV_W-1:0] dev_idx,
  input  logic             load_req,
  input  logic [7:0]       ep_data,
  output logic [EA_W-1:0]  ep_addr,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [15:0]      wr_data,
  output logic             busy,
  output logic             done
);
  localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(N_COEF * 2 - 1);
  localparam logic [WAIT_W-1:0] WAIT_END  = WAIT_W'(RD_LAT - 1);

  ld_state_e         st;
  logic [BYTE_W-1:0] byte_cnt;
  logic [WAIT_W-1:0] wait_cnt;
  logic [7:0]        lo_byte;
  logic              sample;

  assign sample  = (st == LD_RUN) && (wait_cnt == WAIT_END);
  assign busy    = (st == LD_RUN);
  assign ep_addr = {dev_idx, byte_cnt};
  assign wr_en   = sample && byte_cnt[0];
  assign wr_idx  = byte_cnt[BYTE_W-1:1];
  assign wr_data = {ep_data, lo_byte};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= LD_RUN;
      byte_cnt <= '0;
      wait_cnt <= '0;
      lo_byte  <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        LD_IDLE: begin
          if (load_req) begin
            st       <= LD_RUN;
            byte_cnt <= '0;
            wait_cnt <= '0;
          end
        end
        default: begin
          if (sample) begin
            wait_cnt <= '0;
            if (!byte_cnt[0]) lo_byte <= ep_data;
            if (byte_cnt == LAST_BYTE) begin
              st   <= LD_IDLE;
              done <= 1'b1;
            end else begin
              byte_cnt <= byte_cnt + 1'b1;
            end
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/coef_store.sv
module coef_store #(
  parameter int N_COEF  = 128,
  parameter int DEV_W   = 4,
  parameter int RD_LAT  = 3,
  localparam int IDX_W  = $clog2(N_COEF),
  localparam int EA_W   = DEV_W + $clog2(N_COEF * 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEV_W-1:0] dev_idx,
  input  logic             load_req,
  output logic             busy,
  output logic             done,
  output logic [EA_W-1:0]  ep_addr,
  input  logic [7:0]       ep_data,
  input  logic             host_valid,
  output logic             host_ready,
  input  logic [IDX_W-1:0] host_addr,
  input  logic [15:0]      host_data,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [15:0]      rd_data
);
  logic             ld_we;
  logic [IDX_W-1:0] ld_idx;
  logic [15:0]      ld_data;
  logic             mem_we;
  logic [IDX_W-1:0] mem_waddr;
  logic [15:0]      mem_wdata;

  eprom_loader #(.N_COEF(N_COEF), .DEV_W(DEV_W), .RD_LAT(RD_LAT)) u_loader (
    .clk(clk), .rst_n(rst_n), .dev_idx(dev_idx), .load_req(load_req),
    .ep_data(ep_data), .ep_addr(ep_addr), .wr_en(ld_we), .wr_idx(ld_idx),
    .wr_data(ld_data), .busy(busy), .done(done)
  );

  assign host_ready = !busy;
  assign mem_we     = ld_we || (host_valid && host_ready);
  assign mem_waddr  = busy ? ld_idx  : host_addr;
  assign mem_wdata  = busy ? ld_data : host_data;

  coef_ram #(.DEPTH(N_COEF), .W(16)) u_ram (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/coef_store_chk.sv
module coef_store_chk #(
  parameter int EA_W   = 12,
  parameter int BYTE_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            load_req,
  input logic            host_ready,
  input logic [EA_W-1:0] ep_addr
);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R7
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(load_req));
  // R2
  start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (ep_addr[BYTE_W-1:0] == '0));
  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (ep_addr != $past(ep_addr)))
      |-> (ep_addr == $past(ep_addr) + 1'b1));
  // R10
  host_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !host_ready);
endmodule

bind coef_store coef_store_chk #(.EA_W(EA_W), .BYTE_W(EA_W - DEV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .load_req(load_req),
  .host_ready(host_ready), .ep_addr(ep_addr)
);

// File: tb/coef_store_tb.sv
module coef_store_tb;
  localparam int LAT   = 3;
  localparam int NC    = 128;
  localparam int LOADT = NC * 2 * LAT;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  dev_idx = 4'd3;
  logic        load_req = 1'b0;
  logic        busy, done, host_ready;
  logic [11:0] ep_addr;
  logic [7:0]  ep_data;
  logic        host_valid = 1'b0;
  logic [6:0]  host_addr = '0;
  logic [15:0] host_data = '0;
  logic [6:0]  rd_addr = '0;
  logic [15:0] rd_data;

  int total = 0, bad = 0, cyc = 0;
  logic [15:0] model [NC];
  logic [11:0] last_a = '0;
  int stab = 0;

  always #4 clk = ~clk;

  coef_store u_dut (
    .clk(clk), .rst_n(rst_n), .dev_idx(dev_idx), .load_req(load_req),
    .busy(busy), .done(done), .ep_addr(ep_addr), .ep_data(ep_data),
    .host_valid(host_valid), .host_ready(host_ready), .host_addr(host_addr),
    .host_data(host_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] rom(input logic [11:0] a);
    logic [7:0] v;
    v = 8'(a[7:0] * 8'd29) ^ {a[11:8], a[3:0]} ^ 8'h3C;
    return v;
  endfunction

  function automatic logic [15:0] coef_of(input logic [3:0] d, input int i);
    logic [11:0] b;
    b = {d, 8'(2 * i)};
    return {rom(b | 12'd1), rom(b)};
  endfunction

  // EPROM model: correct byte only once the address has been stable long enough
  always @(posedge clk) begin
    stab   <= (ep_addr == last_a) ? stab + 1 : 0;
    last_a <= ep_addr;
  end
  assign ep_data = (ep_addr == last_a && stab >= LAT - 2) ? rom(ep_addr) : ~rom(ep_addr);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run hung, actual=%0d expected<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Follow a download edge by edge after its start; inject disturbances mid-way
  task automatic watch_load(input logic [3:0] d, input bit disturb);
    int n = 0, addr_bad = 0, dones = 0, busy_bad = 0;
    bit fin = 0;
    while (!fin && n < LOADT + 20) begin
      @(posedge clk); n++;
      @(negedge clk);
      host_valid = 1'b0;
      load_req   = 1'b0;
      if (done) begin dones++; fin = 1; end
      else begin
        if (ep_addr != {d, 8'(n / LAT)}) addr_bad++;
        if (!busy) busy_bad++;
      end
      if (disturb && n == 100) begin
        chk(host_ready == 1'b0, "R10 ready low while busy", host_ready, 0);
        host_valid = 1'b1; host_addr = 7'd5; host_data = 16'hDEAD;
      end
      if (disturb && n == 200) load_req = 1'b1;
    end
    chk(n == LOADT, "R1/R7/R8 done timing", n, LOADT);
    chk(addr_bad == 0, "R2/R4 address sequence and hold", addr_bad, 0);
    chk(busy_bad == 0, "R5 busy held during load", busy_bad, 0);
    chk(!busy, "R5/R6 busy low with done", busy, 0);
    @(negedge clk);
    chk(!done, "R6 done single pulse", done, 0);
    for (int i = 0; i < NC; i++) model[i] = coef_of(d, i);
  endtask

  task automatic rd_chk(input int i, input string req);
    rd_addr = 7'(i);
    @(posedge clk);
    @(negedge clk);
    chk(rd_data == model[i], req, rd_data, model[i]);
  endtask

  task automatic host_wr(input int i, input logic [15:0] v);
    host_valid = 1'b1; host_addr = 7'(i); host_data = v;
    chk(host_ready == 1'b1, "R9 ready when idle", host_ready, 1);
    @(posedge clk);
    @(negedge clk);
    host_valid = 1'b0;
    model[i] = v;
  endtask

  initial begin
    int seed = 32'h1A2B;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R1 busy during reset", busy, 1);
    chk(done == 1'b0, "R6 done low in reset", done, 0);
    rst_n = 1'b1;
    // R1 R8 R10: automatic load with a host write and a request injected
    watch_load(4'd3, 1'b1);
    for (int i = 0; i < NC; i++) rd_chk(i, "R3/R10/R11 loaded coefficient");
    // R9: random host writes and reads, plus boundary indices
    host_wr(0, 16'h8001);
    host_wr(NC - 1, 16'h7FFE);
    rd_chk(0, "R9 write index 0");
    rd_chk(NC - 1, "R9 write last index");
    for (int k = 0; k < 80; k++) begin
      if ($urandom % 2) host_wr($urandom % NC, 16'($urandom));
      else rd_chk($urandom % NC, "R9/R11 random access");
    end
    // R7: request-driven reload from another region
    dev_idx = 4'd9;
    load_req = 1'b1;
    chk(busy == 1'b0, "R5 idle before request", busy, 0);
    @(posedge clk);
    @(negedge clk);
    load_req = 1'b0;
    chk(busy == 1'b1, "R7 busy after request", busy, 1);
    chk(ep_addr == 12'h900, "R2 region base", ep_addr, 12'h900);
    watch_load(4'd9, 1'b0);
    for (int i = 0; i < NC; i++) rd_chk(i, "R2/R3/R7 reloaded coefficient");
    // R7: top region
    dev_idx = 4'd15;
    load_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    load_req = 1'b0;
    watch_load(4'd15, 1'b0);
    for (int i = 0; i < NC; i += 9) rd_chk(i, "R2/R3 top region coefficient");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule